// File: doc/BRIEF.md
# Prioritized Interrupt and Trap Arbiter

This block looks at every pending interrupt and trap request and chooses the one the processor core should take next. There are 36 peripheral interrupt sources and 4 trap sources. Each interrupt has a pending flag, an enable and a 3-bit user level. Each trap has a pending flag and a fixed level in the upper half of the 4-bit priority space, so a trap always outranks any interrupt. A source can win only when its level is strictly above the current CPU priority level. A CPU level of 7 therefore shuts out every interrupt but still lets traps through. A trap that is already being serviced raises the CPU level to that trap's level, and a more urgent trap can still nest on top of it.

The winner is placed in registers as a request flag, a vector number and a vector address. These outputs hold until the core acknowledges. In the cycle after the acknowledge, the block drops its request and sends a one-cycle clear strobe to the pending flag of the source it granted. That source is kept out of arbitration while its strobe is active. Reset itself is never arbitrated.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `req_o` is 0 and `clr_o` is all zeros.
- R2: An interrupt is presented only when its user level, widened to 4 bits, is strictly greater than `cpu_lvl_i`. A user level of 0 is never presented.
- R3: When `cpu_lvl_i` is 7 or higher, no interrupt is presented. Pending traps are still presented.
- R4: Trap k has fixed level 15-k and vector number k. Interrupt i has vector number 4+i. Any eligible trap beats every interrupt, and traps are taken in order of their fixed level.
- R5: While `cpu_lvl_i` holds a trap level (8 to 15), a trap with a higher fixed level is still presented. A trap whose level is equal or lower is not.
- R6: Among eligible interrupts that share the same user level, the one with the lowest vector number wins.
- R7: An interrupt with a higher user level wins over one with a lower vector number.
- R8: `addr_o` equals 4 + 2 × `vec_o`, as a 24-bit value.
- R9: Once `req_o` is 1, `req_o`, `vec_o` and `addr_o` stay unchanged until `ack_i` is sampled high. This holds even if a more urgent source arrives in the meantime.
- R10: When `ack_i` is high while `req_o` is 1, in the next cycle `req_o` is 0 and `clr_o` has exactly bit `vec_o` set, for one cycle only. The granted source is not presented again while its strobe is active.
- R11: An interrupt whose enable is 0 is never presented, whatever its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_pend_i | input | 36 | Pending flag of each interrupt source |
| irq_en_i | input | 36 | Enable of each interrupt source |
| irq_lvl_i | input | 108 | 3-bit user level per interrupt, source i at bits [3i+2:3i] |
| trap_pend_i | input | 4 | Pending flag of each trap source |
| cpu_lvl_i | input | 4 | Current CPU priority level |
| ack_i | input | 1 | Core takes the presented request |
| req_o | output | 1 | A request is presented |
| vec_o | output | 6 | Vector number of the presented source |
| addr_o | output | 24 | Vector table address of the presented source |
| clr_o | output | 40 | One-cycle clear strobe, bit index equals vector number |

## Verification
The bench checks the service order when several sources are pending together. It covers same-level ties, a high level against a low vector number, and traps mixed with interrupts. A comparator written the wrong way round, or one that breaks ties the wrong way, would show up here as a swapped order.

It also covers the masking boundaries: a user level equal to the CPU level, level 0, a disabled source, a CPU level of 7 with a trap pending, and nested traps above and at the CPU level. A mask off by one would present a source it should hold back, or hold back one it should present.

A more urgent source arrives while a request is held. A presenter that re-arbitrates would change its vector before the acknowledge. Every grant is followed by a check of the clear strobe. A wrong strobe bit, a strobe that lasts too long, or a source that gets presented twice would all be caught there.

// File: rtl/irq_arb_pkg.sv
// Shared helpers of the interrupt and trap arbiter.
// Assumes that sources are numbered by vector: traps first, then interrupts.
package irq_arb_pkg;

    // Fixed level of trap k: the most urgent trap sits at the top of the level range.
    function automatic int trap_level(input int lvl_bits, input int k);
        return (2 ** lvl_bits) - 1 - k;
    endfunction

    // Vector table offset of vector number idx.
    function automatic int vec_offset(input int base, input int step, input int idx);
        return base + step * idx;
    endfunction

endpackage

// File: rtl/irq_src_qualify.sv
// Turns raw requests into one eligibility bit and one widened level per source,
// indexed by vector number.
// Assumes: traps cannot be masked by an enable; user levels are zero-extended by one bit.
module irq_src_qualify #(
    parameter int N_IRQ  = 36,
    parameter int N_TRAP = 4,
    parameter int ULVL_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_IRQ-1:0]           irq_pend_i,
    input  logic [N_IRQ-1:0]           irq_en_i,
    input  logic [N_IRQ*ULVL_W-1:0]    irq_lvl_i,
    input  logic [N_TRAP-1:0]          trap_pend_i,
    input  logic [ULVL_W:0]            cpu_lvl_i,
    input  logic [N_TRAP+N_IRQ-1:0]    block_i,
    output logic [N_TRAP+N_IRQ-1:0]    elig_o,
    output logic [(N_TRAP+N_IRQ)*(ULVL_W+1)-1:0] lvl_o
);
    localparam int N_SRC  = N_TRAP + N_IRQ;
    localparam int PLVL_W = ULVL_W + 1;

    // Trap sources: fixed level, eligible when pending and above the CPU level.
    for (genvar k = 0; k < N_TRAP; k++) begin : g_trap
        localparam logic [PLVL_W-1:0] FIXED = PLVL_W'(irq_arb_pkg::trap_level(PLVL_W, k));
        assign lvl_o[k*PLVL_W +: PLVL_W] = FIXED;
        assign elig_o[k] = trap_pend_i[k] && !block_i[k] && (FIXED > cpu_lvl_i);
    end

    // Interrupt sources: user level, needs pending, enable and a level above the CPU.
    for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
        logic [PLVL_W-1:0] ulvl;
        assign ulvl = {1'b0, irq_lvl_i[i*ULVL_W +: ULVL_W]};
        assign lvl_o[(N_TRAP+i)*PLVL_W +: PLVL_W] = ulvl;
        assign elig_o[N_TRAP+i] = irq_pend_i[i] && irq_en_i[i] && !block_i[N_TRAP+i]
                                  && (ulvl != '0) && (ulvl > cpu_lvl_i);
    end

    // R3: a CPU level at the user ceiling leaves no interrupt eligible.
    a_r3_irqs_masked_at_7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_lvl_i >= PLVL_W'((2 ** ULVL_W) - 1)) |-> (elig_o[N_SRC-1:N_TRAP] == '0));

endmodule

// File: rtl/irq_pick.sv
// Chooses the eligible source with the highest level; ties go to the lower index.
// Assumes the index equals the vector number, so lower index means natural-order priority.
module irq_pick #(
    parameter int N_SRC  = 40,
    parameter int LVL_W  = 4,
    parameter int VEC_W  = 6
) (
    input  logic [N_SRC-1:0]        elig_i,
    input  logic [N_SRC*LVL_W-1:0]  lvl_i,
    output logic                    found_o,
    output logic [VEC_W-1:0]        win_idx_o,
    output logic [LVL_W-1:0]        win_lvl_o
);
    // Linear scan from the lowest index; a strict compare keeps the first of equals.
    always_comb begin
        found_o   = 1'b0;
        win_idx_o = '0;
        win_lvl_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig_i[i] && (!found_o || (lvl_i[i*LVL_W +: LVL_W] > win_lvl_o))) begin
                found_o   = 1'b1;
                win_idx_o = VEC_W'(i);
                win_lvl_o = lvl_i[i*LVL_W +: LVL_W];
            end
        end
    end

endmodule

// File: rtl/irq_present.sv
// Registers the winner, holds it until acknowledged, then strobes a clear
// for the granted source.
// Assumes ack_i is only meaningful while req_o is high.
module irq_present #(
    parameter int N_SRC    = 40,
    parameter int VEC_W    = 6,
    parameter int ADDR_W   = 24,
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               found_i,
    input  logic [VEC_W-1:0]   win_idx_i,
    input  logic               ack_i,
    output logic               req_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [N_SRC-1:0]   clr_o
);
    localparam logic [N_SRC-1:0] ONE = N_SRC'(1);

    // Capture a winner when idle, hold while presented, release with a clear strobe on ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o  <= 1'b0;
            vec_o  <= '0;
            addr_o <= '0;
            clr_o  <= '0;
        end else begin
            clr_o <= '0;
            if (req_o) begin
                if (ack_i) begin
                    req_o <= 1'b0;
                    clr_o <= ONE << vec_o;
                end
            end else if (found_i) begin
                req_o  <= 1'b1;
                vec_o  <= win_idx_i;
                addr_o <= ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STEP) * ADDR_W'(win_idx_i);
            end
        end
    end

    // R1: outputs are idle just after reset.
    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!req_o && (clr_o == '0)));

    // R9: a presented request does not move until the core acknowledges.
    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(vec_o) && $stable(addr_o)));

    // R10: an acknowledge drops the request and strobes exactly the granted bit.
    a_r10_clear_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i) |=> (!req_o && (clr_o == (ONE << $past(vec_o)))));

    // R10: the strobe lasts one cycle and never names two sources.
    a_r10_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_o != '0) |=> (clr_o == '0));
    a_r10_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_o));

    // R8: a presented address never points below the table start.
    a_r8_addr_at_or_above_base: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (addr_o >= ADDR_W'(VEC_BASE)));

endmodule

// File: rtl/irq_arbiter.sv
// Top of the interrupt and trap arbiter: qualify, pick, present.
// Assumes: pending flags are held outside and cleared by clr_o; the core raises
// cpu_lvl_i to the level of whatever it is servicing.
module irq_arbiter #(
    parameter int N_IRQ    = 36,
    parameter int N_TRAP   = 4,
    parameter int ULVL_W   = 3,
    parameter int ADDR_W   = 24,
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [N_IRQ-1:0]                    irq_pend_i,
    input  logic [N_IRQ-1:0]                    irq_en_i,
    input  logic [N_IRQ*ULVL_W-1:0]             irq_lvl_i,
    input  logic [N_TRAP-1:0]                   trap_pend_i,
    input  logic [ULVL_W:0]                     cpu_lvl_i,
    input  logic                                ack_i,
    output logic                                req_o,
    output logic [$clog2(N_TRAP+N_IRQ)-1:0]     vec_o,
    output logic [ADDR_W-1:0]                   addr_o,
    output logic [N_TRAP+N_IRQ-1:0]             clr_o
);
    localparam int N_SRC  = N_TRAP + N_IRQ;
    localparam int VEC_W  = $clog2(N_SRC);
    localparam int PLVL_W = ULVL_W + 1;

    logic [N_SRC-1:0]        elig;
    logic [N_SRC*PLVL_W-1:0] lvl;
    logic                    found;
    logic [VEC_W-1:0]        win_idx;
    logic [PLVL_W-1:0]       win_lvl;

    irq_src_qualify #(.N_IRQ(N_IRQ), .N_TRAP(N_TRAP), .ULVL_W(ULVL_W)) i_qualify (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_pend_i  (irq_pend_i),
        .irq_en_i    (irq_en_i),
        .irq_lvl_i   (irq_lvl_i),
        .trap_pend_i (trap_pend_i),
        .cpu_lvl_i   (cpu_lvl_i),
        .block_i     (clr_o),
        .elig_o      (elig),
        .lvl_o       (lvl)
    );

    irq_pick #(.N_SRC(N_SRC), .LVL_W(PLVL_W), .VEC_W(VEC_W)) i_pick (
        .elig_i    (elig),
        .lvl_i     (lvl),
        .found_o   (found),
        .win_idx_o (win_idx),
        .win_lvl_o (win_lvl)
    );

    irq_present #(.N_SRC(N_SRC), .VEC_W(VEC_W), .ADDR_W(ADDR_W),
                  .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) i_present (
        .clk       (clk),
        .rst_n     (rst_n),
        .found_i   (found),
        .win_idx_i (win_idx),
        .ack_i     (ack_i),
        .req_o     (req_o),
        .vec_o     (vec_o),
        .addr_o    (addr_o),
        .clr_o     (clr_o)
    );

    // R4: with any trap eligible, the pick lands on a trap.
    a_r4_trap_first: assert property (@(posedge clk) disable iff (!rst_n)
        (found && (elig[N_TRAP-1:0] != '0)) |-> (win_idx < VEC_W'(N_TRAP)));

    // R2: a newly raised request came from a level above the CPU level.
    a_r2_level_above_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> ($past(win_lvl) > $past(cpu_lvl_i)));

endmodule

// File: tb/test_irq_arbiter.sv
// Scoreboard bench: scenario tasks queue the expected service order, a monitor
// pops on each presented request, checks hold, vector, address and clear strobe,
// then acknowledges.
module test_irq_arbiter;
    localparam int  CLK_PERIOD = 10;
    localparam int  NI = 36;
    localparam int  NT = 4;
    localparam int  NS = NI + NT;
    localparam int  HOLD = 2;
    localparam int  WATCHDOG = 20000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   src_pend = '0;
    logic [NS-1:0]   set_v = '0;
    logic [NS-1:0]   drop_v = '0;
    logic [NI-1:0]   irq_en = '1;
    logic [NI*3-1:0] irq_lvl = '0;
    logic [3:0]      cpu_lvl = '0;
    logic            ack = 1'b0;
    logic            req;
    logic [5:0]      vec;
    logic [23:0]     addr;
    logic [NS-1:0]   clr;

    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_arbiter i_irq_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_pend_i  (src_pend[NS-1:NT]),
        .irq_en_i    (irq_en),
        .irq_lvl_i   (irq_lvl),
        .trap_pend_i (src_pend[NT-1:0]),
        .cpu_lvl_i   (cpu_lvl),
        .ack_i       (ack),
        .req_o       (req),
        .vec_o       (vec),
        .addr_o      (addr),
        .clr_o       (clr)
    );

    // Pending flags as the surrounding logic keeps them: set by the bench, cleared by the strobe.
    always @(posedge clk) begin
        if (!rst_n) src_pend <= '0;
        else        src_pend <= (src_pend | set_v) & ~clr & ~drop_v;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic set_lvl(input int irq, input int l);
        irq_lvl[irq*3 +: 3] = 3'(l);
    endtask

    task automatic pulse_set(input logic [NS-1:0] m);
        @(negedge clk); set_v = m;
        @(negedge clk); set_v = '0;
    endtask

    task automatic pulse_drop(input logic [NS-1:0] m);
        @(negedge clk); drop_v = m;
        @(negedge clk); drop_v = '0;
    endtask

    function automatic logic [NS-1:0] bit_of(input int v);
        return NS'(1) << v;
    endfunction

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic expect_idle(input string tag);
        repeat (4) @(negedge clk);
        chk(req == 1'b0, tag, int'(req), 0);
    endtask

    // Monitor: compare each presented request against the scoreboard, then acknowledge.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && req) begin
                int v0;
                int e;
                v0 = int'(vec);
                for (int h = 0; h < HOLD; h++) begin
                    @(negedge clk);
                    chk(req && int'(vec) == v0, "R9 hold until ack", int'(vec), v0);
                end
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2/R3/R5/R11 unexpected request", v0, -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(v0 == e, "R4/R6/R7 service order", v0, e);
                    chk(int'(addr) == 4 + 2 * e, "R8 vector address", int'(addr), 4 + 2 * e);
                end
                ack = 1'b1;
                @(negedge clk);
                ack = 1'b0;
                chk(clr == bit_of(v0) && !req, "R10 clear strobe", int'(clr != '0), 1);
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req == 1'b0 && clr == '0, "R1 reset idle", int'(req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req == 1'b0 && clr == '0, "R1 after reset", int'(req), 0);

        // R2 R8: single interrupt 5 at level 3 -> vector 9, address 22
        set_lvl(5, 3);
        exp_q.push_back(9);
        pulse_set(bit_of(9));
        drain();

        // R6: equal level 4 on interrupts 10, 3, 7 -> vectors 7, 11, 14
        set_lvl(10, 4); set_lvl(3, 4); set_lvl(7, 4);
        exp_q.push_back(7); exp_q.push_back(11); exp_q.push_back(14);
        pulse_set(bit_of(14) | bit_of(7) | bit_of(11));
        drain();

        // R7: levels beat vector order -> 24, 34, then 6
        set_lvl(2, 1); set_lvl(30, 6); set_lvl(20, 6);
        exp_q.push_back(24); exp_q.push_back(34); exp_q.push_back(6);
        pulse_set(bit_of(6) | bit_of(34) | bit_of(24));
        drain();

        // R2: CPU level 3 admits level 4 only; level 3 waits until the CPU drops to 2
        cpu_lvl = 4'd3;
        set_lvl(0, 3); set_lvl(1, 4);
        exp_q.push_back(5);
        pulse_set(bit_of(4) | bit_of(5));
        drain();
        expect_idle("R2 equal level held back");
        exp_q.push_back(4);
        cpu_lvl = 4'd2;
        drain();
        cpu_lvl = 4'd0;

        // R2 R11: level 0 and a disabled level-7 source are never presented
        set_lvl(6, 0); set_lvl(7, 7);
        irq_en[7] = 1'b0;
        pulse_set(bit_of(10) | bit_of(11));
        expect_idle("R2/R11 level 0 or disabled");
        pulse_drop(bit_of(10) | bit_of(11));
        irq_en[7] = 1'b1;
        exp_q.push_back(11);
        pulse_set(bit_of(11));
        drain();

        // R3: CPU level 7 blocks a level-7 interrupt but admits trap 3
        cpu_lvl = 4'd7;
        set_lvl(12, 7);
        exp_q.push_back(3);
        pulse_set(bit_of(16) | bit_of(3));
        drain();
        expect_idle("R3 interrupts masked at level 7");
        pulse_drop(bit_of(16));
        cpu_lvl = 4'd0;

        // R4: traps 1 and 3 go before a level-7 interrupt 0
        set_lvl(0, 7);
        exp_q.push_back(1); exp_q.push_back(3); exp_q.push_back(4);
        pulse_set(bit_of(4) | bit_of(1) | bit_of(3));
        drain();

        // R5: nesting at CPU level 12: traps 0 and 2 admitted, trap 3 (level 12) not
        cpu_lvl = 4'd12;
        exp_q.push_back(0); exp_q.push_back(2);
        pulse_set(bit_of(0) | bit_of(2) | bit_of(3));
        drain();
        expect_idle("R5 equal trap level held back");
        pulse_drop(bit_of(3));
        cpu_lvl = 4'd0;

        // R9: a more urgent source arriving during the hold does not replace the request
        set_lvl(8, 2); set_lvl(9, 7);
        exp_q.push_back(12); exp_q.push_back(13);
        pulse_set(bit_of(12));
        @(negedge clk);
        pulse_set(bit_of(13));
        drain();

        // R8: last interrupt 35 -> vector 39, address 82
        set_lvl(35, 1);
        exp_q.push_back(39);
        pulse_set(bit_of(39));
        drain();

        chk(exp_q.size() == 0, "R10 all grants consumed", exp_q.size(), 0);
        finish_run();
    end

endmodule